// File: doc/BRIEF.md
# Speculative Write Buffer Line Merger

This block holds the speculative stores of four cores running ordered threads and builds a full 32-byte line for any core whose private cache misses. Each core owns a write buffer. A store enters the buffer of the core that issued it, one byte at a time, tagged by line address, and with a byte-valid mask. A simple L2 array sits behind the buffers. At any time one core is the head. It runs the oldest, non-speculative thread. Thread order runs from the head upward, wrapping modulo four, so the age of a core is `(core - head) mod 4`.

When a core requests a line, the L2 line and all four buffers are read in the same cycle. For each byte, a priority chain picks the youngest buffer whose age is not greater than the requester's age and which has that byte valid. If no eligible buffer has the byte, it comes from L2. Buffers of later threads never contribute. A squash discards one core's buffer. A commit drains the head's buffer into L2 one line per cycle, and then passes head status to the next core. A non-head core whose buffer is full is stalled. A head core with a full buffer writes a new line's byte straight into L2.

Top module: `swb_line_merger`

## Requirements
- R1: After reset, all buffers are empty, core 0 is head, no stall or drain output is active, and L2 line `l` byte `b` holds `(7*l + b) mod 128`.
- R2: A store writes one byte into its own core's buffer. Further stores to the same line merge into the same entry, and a later store to a byte overwrites the earlier one.
- R3: `rd_valid` rises in the cycle after `rd_req`. `rd_data` reflects the buffers and L2 as they stood in the request cycle, with L2 and every buffer looked up together.
- R4: Each returned byte comes from the youngest buffer, by age `(core - head) mod 4`, that is not younger than the requester and holds that byte valid.
- R5: A byte that no eligible buffer holds comes from L2. Buffers of threads younger than the requester never supply bytes.
- R6: `squash` empties every entry of buffer `squash_core` at the next edge. A store from that core in the same cycle is lost.
- R7: A `commit` starts a drain in which the head buffer emits one line per cycle on `dr_valid`/`dr_line`/`dr_mask`/`dr_data` (mask bit `b` covers data bits `8b+7:8b`), and L2 takes the masked bytes. While the drain runs, `stall[head]` is high and stores from the head core are ignored.
- R8: One cycle after the head buffer is empty during a drain, head moves to `(head+1) mod 4` and `stall` of the old head falls. A `commit` during a drain has no effect.
- R9: A non-head core has `stall` high exactly when all `DEPTH` entries of its buffer are in use. In that state, a store to a new line is dropped, and a store to a line already held still merges.
- R10: A store from the head core to a new line when its buffer is full is written directly into L2 at that byte.
- R11: A read issued during a drain cycle returns the same line it would have returned before the commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| st_valid | input | CORES | Per-core store strobe |
| st_line | input | CORES*LAW | Per-core store line address |
| st_byte | input | CORES*5 | Per-core byte offset within the line |
| st_data | input | CORES*8 | Per-core store byte |
| stall | output | CORES | Per-core stall |
| rd_req | input | 1 | Line read request |
| rd_core | input | 2 | Requesting core |
| rd_line | input | LAW | Requested line address |
| rd_valid | output | 1 | Read response strobe |
| rd_data | output | 256 | Assembled line, byte b at bits 8b+7:8b |
| commit | input | 1 | Start draining the head buffer |
| squash | input | 1 | Discard one buffer |
| squash_core | input | 2 | Core whose buffer is discarded |
| dr_valid | output | 1 | Drain port line valid |
| dr_line | output | LAW | Drained line address |
| dr_mask | output | 32 | Drained byte-valid mask |
| dr_data | output | 256 | Drained line data |

## Verification
A line read and a drain write to L2 can fall in the same cycle. The same line is then moving from the head buffer into L2 while another core assembles it. The bench computes the expected line for a non-head requester before raising `commit`. It issues that read in the first drain cycle, together with a head-core store that must be ignored. It then requires the response to equal the pre-commit prediction, and the drained mask and data to match the head's stores. Later reads of the same line, and of the line the ignored store targeted, confirm the L2 contents after the drain.

// File: rtl/swb_pkg.sv
// Shared constants and types for the speculative write buffer line merger.
// Assumes a power-of-two core count, so thread age wraps by plain subtraction.
package swb_pkg;
    localparam int CORES      = 4;
    localparam int CORE_W     = $clog2(CORES);
    localparam int LINE_BYTES = 32;
    localparam int BOFF_W     = $clog2(LINE_BYTES);
    localparam int LINE_W     = LINE_BYTES * 8;

    typedef logic [LINE_BYTES-1:0] bmask_t;
    typedef logic [LINE_W-1:0]     line_t;
endpackage

// File: rtl/swb_buffer.sv
// One core's speculative write buffer: DEPTH line entries, each holding a tag,
// a byte-valid mask and line data. Performs a tag lookup for line assembly and
// presents its lowest valid entry for draining. Assumes tags stay unique
// (a store matches an existing entry before a new one is allocated).
module swb_buffer
    import swb_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int LAW   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_valid,
    input  logic [LAW-1:0]    st_line,
    input  logic [BOFF_W-1:0] st_byte,
    input  logic [7:0]        st_data,
    input  logic              clear,
    input  logic              pop,
    input  logic [LAW-1:0]    lk_line,
    output bmask_t            lk_mask,
    output line_t             lk_data,
    output logic              st_accept,
    output logic              full,
    output logic              empty,
    output logic              dr_valid,
    output logic [LAW-1:0]    dr_line,
    output bmask_t            dr_mask,
    output line_t             dr_data
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DEPTH-1:0] vld_q;
    logic [LAW-1:0]   tag_q [DEPTH];
    bmask_t           msk_q [DEPTH];
    line_t            dat_q [DEPTH];

    logic          m_hit, f_hit, d_hit;
    logic [IW-1:0] m_idx, f_idx, d_idx, w_idx;

    // Find the matching entry, lowest free entry, lowest valid entry and lookup hit.
    always_comb begin
        m_hit   = 1'b0; m_idx = '0;
        f_hit   = 1'b0; f_idx = '0;
        d_hit   = 1'b0; d_idx = '0;
        lk_mask = '0;   lk_data = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (vld_q[i] && tag_q[i] == st_line) begin m_hit = 1'b1; m_idx = IW'(i); end
            if (!vld_q[i]) begin f_hit = 1'b1; f_idx = IW'(i); end
            if (vld_q[i]) begin d_hit = 1'b1; d_idx = IW'(i); end
            if (vld_q[i] && tag_q[i] == lk_line) begin
                lk_mask = msk_q[i];
                lk_data = dat_q[i];
            end
        end
    end

    assign st_accept = m_hit | f_hit;
    assign w_idx     = m_hit ? m_idx : f_idx;
    assign full      = &vld_q;
    assign empty     = ~|vld_q;
    assign dr_valid  = d_hit;
    assign dr_line   = tag_q[d_idx];
    assign dr_mask   = msk_q[d_idx];
    assign dr_data   = dat_q[d_idx];

    // Entry valid bits: squash clears all, drain pops one, stores allocate.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            vld_q <= '0;
        end else begin
            if (pop && d_hit) vld_q[d_idx] <= 1'b0;
            if (st_valid && st_accept) vld_q[w_idx] <= 1'b1;
        end
    end

    // Entry payload: tag, byte mask and the stored byte.
    always_ff @(posedge clk) begin
        if (rst_n && !clear && st_valid && st_accept) begin
            tag_q[w_idx] <= st_line;
            msk_q[w_idx] <= (m_hit ? msk_q[w_idx] : '0) | (bmask_t'(1) << st_byte);
            dat_q[w_idx][st_byte*8 +: 8] <= st_data;
        end
    end
endmodule

// File: rtl/swb_merge.sv
// Per-byte priority merge. Walks the buffers from the head (oldest) up to the
// requester and keeps the youngest valid byte; otherwise keeps the L2 byte.
// Assumes each buffer's lookup outputs are zero-masked on a miss.
module swb_merge
    import swb_pkg::*;
(
    input  logic [CORE_W-1:0] head,
    input  logic [CORE_W-1:0] req_core,
    input  line_t             l2_data,
    input  bmask_t            lk_mask [CORES],
    input  line_t             lk_data [CORES],
    output line_t             merged
);
    logic [CORE_W-1:0] req_age;
    assign req_age = req_core - head;

    for (genvar b = 0; b < LINE_BYTES; b++) begin : g_byte
        logic [7:0] sel_b;
        // Priority chain for byte b, later (younger) eligible buffers win.
        always_comb begin
            sel_b = l2_data[b*8 +: 8];
            for (int k = 0; k < CORES; k++) begin
                if (k <= int'(req_age) && lk_mask[CORE_W'(head + CORE_W'(k))][b])
                    sel_b = lk_data[CORE_W'(head + CORE_W'(k))][b*8 +: 8];
            end
        end
        assign merged[b*8 +: 8] = sel_b;
    end
endmodule

// File: rtl/swb_l2.sv
// Simple L2 line array with one combinational read port and one byte-masked
// write port. Resets to a fixed arithmetic pattern so contents are predictable.
module swb_l2
    import swb_pkg::*;
#(
    parameter int LINES = 16,
    parameter int LAW   = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [LAW-1:0] rd_line,
    output line_t          rd_data,
    input  logic           wr_en,
    input  logic [LAW-1:0] wr_line,
    input  bmask_t         wr_mask,
    input  line_t          wr_data
);
    line_t mem_q [LINES];

    assign rd_data = mem_q[rd_line];

    // Reset pattern load, then masked byte writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int l = 0; l < LINES; l++)
                for (int b = 0; b < LINE_BYTES; b++)
                    mem_q[l][b*8 +: 8] <= 8'((l * 7 + b) % 128);
        end else if (wr_en) begin
            for (int b = 0; b < LINE_BYTES; b++)
                if (wr_mask[b]) mem_q[wr_line][b*8 +: 8] <= wr_data[b*8 +: 8];
        end
    end
endmodule

// File: rtl/swb_line_merger.sv
// Top: four per-core speculative write buffers, an L2 array, the per-byte
// merge for line reads, head tracking, commit drain and squash. Assumes at
// most one store per core per cycle and one read request per cycle.
module swb_line_merger
    import swb_pkg::*;
#(
    parameter int DEPTH    = 16,
    parameter int L2_LINES = 16,
    localparam int LAW     = $clog2(L2_LINES)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [CORES-1:0]          st_valid,
    input  logic [CORES*LAW-1:0]      st_line,
    input  logic [CORES*BOFF_W-1:0]   st_byte,
    input  logic [CORES*8-1:0]        st_data,
    output logic [CORES-1:0]          stall,
    input  logic                      rd_req,
    input  logic [CORE_W-1:0]         rd_core,
    input  logic [LAW-1:0]            rd_line,
    output logic                      rd_valid,
    output logic [LINE_W-1:0]         rd_data,
    input  logic                      commit,
    input  logic                      squash,
    input  logic [CORE_W-1:0]         squash_core,
    output logic                      dr_valid,
    output logic [LAW-1:0]            dr_line,
    output logic [LINE_BYTES-1:0]     dr_mask,
    output logic [LINE_W-1:0]         dr_data
);
    logic [CORE_W-1:0] head_q;
    logic              drain_q;

    logic [CORES-1:0] st_go, clr, acc, full_v, empty_v, dvld_v;
    logic [LAW-1:0]   dline [CORES];
    bmask_t           dmask [CORES];
    line_t            ddata [CORES];
    bmask_t           lkmask [CORES];
    line_t            lkdata [CORES];
    line_t            l2_rd, merged;

    for (genvar c = 0; c < CORES; c++) begin : g_core
        logic is_head;
        assign is_head = (head_q == CORE_W'(c));
        assign st_go[c] = st_valid[c] & ~(is_head & drain_q);
        assign clr[c]   = squash & (squash_core == CORE_W'(c));
        assign stall[c] = is_head ? drain_q : full_v[c];

        swb_buffer #(.DEPTH(DEPTH), .LAW(LAW)) u_buf (
            .clk(clk), .rst_n(rst_n),
            .st_valid(st_go[c]),
            .st_line(st_line[c*LAW +: LAW]),
            .st_byte(st_byte[c*BOFF_W +: BOFF_W]),
            .st_data(st_data[c*8 +: 8]),
            .clear(clr[c]),
            .pop(is_head & drain_q),
            .lk_line(rd_line),
            .lk_mask(lkmask[c]), .lk_data(lkdata[c]),
            .st_accept(acc[c]), .full(full_v[c]), .empty(empty_v[c]),
            .dr_valid(dvld_v[c]), .dr_line(dline[c]),
            .dr_mask(dmask[c]), .dr_data(ddata[c])
        );
    end

    // Head buffer drain port.
    assign dr_valid = drain_q & dvld_v[head_q];
    assign dr_line  = dline[head_q];
    assign dr_mask  = dmask[head_q];
    assign dr_data  = ddata[head_q];

    // Head store that finds its buffer full goes straight to L2.
    logic              direct_wr;
    logic [BOFF_W-1:0] hd_byte;
    logic [7:0]        hd_data;
    assign hd_byte   = st_byte[head_q*BOFF_W +: BOFF_W];
    assign hd_data   = st_data[head_q*8 +: 8];
    assign direct_wr = st_valid[head_q] & ~drain_q & ~acc[head_q];

    logic           l2_we;
    logic [LAW-1:0] l2_wline;
    bmask_t         l2_wmask;
    line_t          l2_wdata;

    // Select the L2 write source: drain line or direct head byte.
    always_comb begin
        l2_we    = dr_valid | direct_wr;
        l2_wline = dr_valid ? dr_line : st_line[head_q*LAW +: LAW];
        l2_wmask = dr_valid ? dr_mask : (bmask_t'(1) << hd_byte);
        l2_wdata = dr_valid ? dr_data : {LINE_BYTES{hd_data}};
    end

    swb_l2 #(.LINES(L2_LINES), .LAW(LAW)) u_l2 (
        .clk(clk), .rst_n(rst_n),
        .rd_line(rd_line), .rd_data(l2_rd),
        .wr_en(l2_we), .wr_line(l2_wline),
        .wr_mask(l2_wmask), .wr_data(l2_wdata)
    );

    swb_merge u_merge (
        .head(head_q), .req_core(rd_core), .l2_data(l2_rd),
        .lk_mask(lkmask), .lk_data(lkdata), .merged(merged)
    );

    // Commit sequencing: start a drain, advance head once the head buffer is empty.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q  <= '0;
            drain_q <= 1'b0;
        end else if (!drain_q) begin
            if (commit) drain_q <= 1'b1;
        end else if (!dvld_v[head_q]) begin
            drain_q <= 1'b0;
            head_q  <= head_q + 1'b1;
        end
    end

    // Registered read response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_req;
            if (rd_req) rd_data <= merged;
        end
    end
endmodule

// File: rtl/swb_line_merger_chk.sv
// Assertion checker for swb_line_merger, attached by bind below. Observes
// ports plus head, drain state and per-buffer occupancy.
module swb_line_merger_chk
    import swb_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  rd_req,
    input logic                  rd_valid,
    input logic                  commit,
    input logic                  squash,
    input logic [CORE_W-1:0]     squash_core,
    input logic                  dr_valid,
    input logic [LINE_BYTES-1:0] dr_mask,
    input logic                  drain_q,
    input logic [CORE_W-1:0]     head_q,
    input logic [CORES-1:0]      stall,
    input logic [CORES-1:0]      buf_full,
    input logic [CORES-1:0]      buf_empty
);
    // R3
    rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n) rd_req |=> rd_valid);
    // R3
    rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) !rd_req |=> !rd_valid);
    // R6
    squash_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        squash |=> buf_empty[$past(squash_core)]);
    // R7
    drain_gate_chk: assert property (@(posedge clk) disable iff (!rst_n) dr_valid |-> drain_q);
    // R7
    drain_mask_chk: assert property (@(posedge clk) disable iff (!rst_n) dr_valid |-> (dr_mask != '0));
    // R7
    head_stall_chk: assert property (@(posedge clk) disable iff (!rst_n) stall[head_q] |-> drain_q);
    // R8
    commit_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !drain_q) |=> drain_q);
    // R8
    head_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (head_q != $past(head_q)) |-> ($past(drain_q) && head_q == CORE_W'($past(head_q) + 1'b1)));

    for (genvar c = 0; c < CORES; c++) begin : g_stall
        // R9
        nonhead_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (stall[c] && head_q != CORE_W'(c)) |-> buf_full[c]);
    end
endmodule

bind swb_line_merger swb_line_merger_chk u_chk (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_valid(rd_valid),
    .commit(commit), .squash(squash), .squash_core(squash_core),
    .dr_valid(dr_valid), .dr_mask(dr_mask), .drain_q(drain_q), .head_q(head_q),
    .stall(stall), .buf_full(full_v), .buf_empty(empty_v)
);

// File: tb/swb_line_merger_tb.sv
module swb_line_merger_tb;
    import swb_pkg::*;
    localparam int CLK_P = 10;
    localparam int DEPTH = 4;
    localparam int L2L   = 16;
    localparam int LAW   = $clog2(L2L);

    logic clk = 0, rst_n = 0;
    logic [CORES-1:0] st_valid = '0;
    logic [CORES*LAW-1:0] st_line = '0;
    logic [CORES*BOFF_W-1:0] st_byte = '0;
    logic [CORES*8-1:0] st_data = '0;
    logic [CORES-1:0] stall;
    logic rd_req = 0; logic [CORE_W-1:0] rd_core = '0; logic [LAW-1:0] rd_line = '0;
    logic rd_valid; logic [LINE_W-1:0] rd_data;
    logic commit = 0, squash = 0; logic [CORE_W-1:0] squash_core = '0;
    logic dr_valid; logic [LAW-1:0] dr_line; logic [LINE_BYTES-1:0] dr_mask; logic [LINE_W-1:0] dr_data;

    swb_line_merger #(.DEPTH(DEPTH), .L2_LINES(L2L)) u_dut (.*);

    always #(CLK_P/2) clk = ~clk;

    int checks = 0, errors = 0, head_m = 0;
    logic [31:0] mv [CORES][L2L];
    logic [7:0]  md [CORES][L2L][LINE_BYTES];
    logic [7:0]  l2m [L2L][LINE_BYTES];

    task automatic chk(bit ok, string req, string what, logic [LINE_W-1:0] act, logic [LINE_W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte(int r, int ln, int b);
        int ra = (r - head_m + CORES) % CORES;
        logic [7:0] v = l2m[ln][b];
        for (int k = 0; k <= ra; k++) begin
            int c = (head_m + k) % CORES;
            if (mv[c][ln][b]) v = md[c][ln][b];
        end
        return v;
    endfunction

    function automatic logic [LINE_W-1:0] exp_line(int r, int ln);
        logic [LINE_W-1:0] e;
        for (int b = 0; b < LINE_BYTES; b++) e[b*8 +: 8] = exp_byte(r, ln, b);
        return e;
    endfunction

    // Drive one store (no clock) and update the model per R2/R9/R10.
    task automatic put(int c, int ln, int b, logic [7:0] d);
        int used = 0;
        st_valid[c] = 1'b1;
        st_line[c*LAW +: LAW] = LAW'(ln);
        st_byte[c*BOFF_W +: BOFF_W] = BOFF_W'(b);
        st_data[c*8 +: 8] = d;
        for (int l = 0; l < L2L; l++) if (mv[c][l] != 0) used++;
        if (mv[c][ln] != 0 || used < DEPTH) begin
            mv[c][ln][b] = 1'b1; md[c][ln][b] = d;
        end else if (c == head_m) begin
            l2m[ln][b] = d;
        end
    endtask

    task automatic tick();
        @(negedge clk);
        st_valid = '0;
    endtask

    task automatic rd_check(int r, int ln, string req);
        logic [LINE_W-1:0] e;
        rd_req = 1; rd_core = CORE_W'(r); rd_line = LAW'(ln);
        e = exp_line(r, ln);
        @(negedge clk);
        rd_req = 0;
        chk(rd_valid === 1'b1 && rd_data === e, req, $sformatf("read core%0d line%0d", r, ln), rd_data, e);
    endtask

    task automatic do_squash(int c);
        squash = 1; squash_core = CORE_W'(c);
        @(negedge clk);
        squash = 0;
        for (int l = 0; l < L2L; l++) mv[c][l] = '0;
    endtask

    // Commit with a concurrent read (R11) and an ignored head store (R7).
    task automatic do_commit(int rq, int ln);
        int h = head_m, nd = 0, want = 0, guard = 0;
        logic [LINE_W-1:0] e = exp_line(rq, ln);
        for (int l = 0; l < L2L; l++) if (mv[h][l] != 0) want++;
        commit = 1;
        @(negedge clk);
        commit = 0;
        rd_req = 1; rd_core = CORE_W'(rq); rd_line = LAW'(ln);
        st_valid[h] = 1'b1; st_line[h*LAW +: LAW] = '0; st_byte[h*BOFF_W +: BOFF_W] = '0; st_data[h*8 +: 8] = 8'hFF;
        while (stall[h] && guard < 40) begin
            if (dr_valid) begin
                logic ok = (dr_mask === mv[h][dr_line]);
                for (int b = 0; b < LINE_BYTES; b++)
                    if (mv[h][dr_line][b] && dr_data[b*8 +: 8] !== md[h][dr_line][b]) ok = 0;
                chk(ok, "R7", $sformatf("drain line%0d mask/data", dr_line), {224'b0, dr_mask}, {224'b0, mv[h][dr_line]});
                nd++;
            end
            @(negedge clk);
            st_valid = '0;
            if (guard == 0) begin
                rd_req = 0;
                chk(rd_valid === 1'b1 && rd_data === e, "R11", "read during drain", rd_data, e);
            end
            guard++;
        end
        chk(nd == want, "R7", "drained line count", LINE_W'(nd), LINE_W'(want));
        chk(guard > 0 && guard <= want + 1 && stall[h] == 1'b0, "R8", "drain end and old head unstall",
            LINE_W'(guard), LINE_W'(want + 1));
        for (int l = 0; l < L2L; l++) begin
            for (int b = 0; b < LINE_BYTES; b++) if (mv[h][l][b]) l2m[l][b] = md[h][l][b];
            mv[h][l] = '0;
        end
        head_m = (h + 1) % CORES;
    endtask

    initial begin
        #(CLK_P * 150000);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int c = 0; c < CORES; c++) for (int l = 0; l < L2L; l++) mv[c][l] = '0;
        for (int l = 0; l < L2L; l++) for (int b = 0; b < LINE_BYTES; b++) l2m[l][b] = 8'((l * 7 + b) % 128);
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        chk(stall === '0 && rd_valid === 1'b0 && dr_valid === 1'b0, "R1", "reset outputs",
            {stall, rd_valid, dr_valid}, '0);
        rd_check(0, 0, "R1");
        rd_check(3, 11, "R1");

        // R2 merge and overwrite within one line
        put(0, 9, 3, 8'hA1); tick();
        put(0, 9, 3, 8'hA2); tick();
        put(0, 9, 4, 8'hA3); tick();
        rd_check(0, 9, "R2");
        rd_check(2, 9, "R2");

        // R4 R5 sweep: every subset of writers per byte, every requester, every head
        for (int rd = 0; rd < CORES; rd++) begin
            int ln = rd + 1;
            for (int c = 0; c < CORES; c++) do_squash(c);
            for (int b = 0; b < LINE_BYTES; b++) begin
                for (int c = 0; c < CORES; c++)
                    if (((b ^ rd) >> c) & 1) put(c, ln, b, 8'(8'h80 | (c << 5) | b));
                tick();
            end
            for (int r = 0; r < CORES; r++) rd_check(r, ln, "R4");
            // R6 squash the youngest thread and re-read
            do_squash((head_m + 3) % CORES);
            rd_check((head_m + 3) % CORES, ln, "R6");
            rd_check(head_m, ln, "R5");
            do_commit((head_m + 2) % CORES, ln);
            for (int r = 0; r < CORES; r++) rd_check(r, ln, "R8");
        end
        rd_check(head_m, 0, "R7");

        // R6 squash beats a store in the same cycle
        for (int c = 0; c < CORES; c++) do_squash(c);
        put(1, 9, 7, 8'hC7);
        squash = 1; squash_core = 2'd1;
        tick();
        squash = 0;
        for (int l = 0; l < L2L; l++) mv[1][l] = '0;
        rd_check(1, 9, "R6");

        // R9 fill a non-head buffer
        for (int i = 0; i < DEPTH; i++) begin put(1, 10 + i, 0, 8'(8'hD0 + i)); tick(); end
        chk(stall[1] === 1'b1 && stall[0] === 1'b0, "R9", "non-head full stall", {252'b0, stall}, {252'b0, 4'b0010});
        put(1, 14, 1, 8'hDE); tick();
        rd_check(1, 14, "R9");
        put(1, 10, 5, 8'hDF); tick();
        rd_check(1, 10, "R9");

        // R10 head full writes through to L2
        for (int i = 0; i < DEPTH; i++) begin put(0, 10 + i, 2, 8'(8'hB0 + i)); tick(); end
        chk(stall[0] === 1'b0, "R10", "head full no stall", {255'b0, stall[0]}, '0);
        put(0, 15, 2, 8'hEE); tick();
        rd_check(0, 15, "R10");
        rd_check(3, 15, "R10");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule